// File: doc/BRIEF.md
# Flash Command Write Sequencer

This block polices the three writes that software must issue to start a flash operation. First comes a write into the flash array window, which supplies the target address and data. Next comes a write of an operation code to the command register. Last comes a write of 1 to the buffer-empty status bit, which launches the operation. Five operations exist: blank check, page erase verify, program, page erase and mass erase. Any write that breaks this order aborts the sequence and raises an access error. A protection hit during the array write raises a protection violation instead.

A launched operation goes into a single pending slot. From there it passes to the execution engine as soon as the engine is idle. While one operation runs, software can therefore stage and launch the next one. The command-complete flag drops on launch. It returns only when the engine reports done and nothing is waiting in the pending slot. The error flags are write-1-to-clear. While either error flag is set, no new sequence can start.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, buffer-empty and command-complete read 1, while access-error, protection-violation, divider-loaded and `exec_start` read 0.
- R2: The sequence array write, then command write (codes 0x11 blank check, 0x12 page erase verify, 0x21 program, 0x31 page erase, 0x32 mass erase), then a status write with bit 0 set produces one `exec_start` pulse. That pulse carries the staged address and data and an `exec_op` of 0, 1, 2, 3 or 4 respectively.
- R3: On the clock edge that captures a valid launch, command-complete and buffer-empty both go to 0. Buffer-empty returns to 1 on the edge at which the command moves to an idle engine.
- R4: Command-complete sets only on an edge where `exec_done` is high while a command runs and the pending slot is empty. A launched command waits in the pending slot, keeping buffer-empty at 0, until the running command reports done.
- R5: Out-of-order writes set access-error and abort the sequence. These are a command write not preceded by an array write, a second array write, a launch with no command staged, a divider write in mid-sequence, or an array write and a register write in the same cycle.
- R6: A command write whose code is not one of the five listed codes sets access-error and starts nothing.
- R7: A launch while divider-loaded is 0 sets access-error and starts nothing. Any write to the divider register (`reg_sel` 2) outside a sequence sets divider-loaded.
- R8: An array write with `prot_hit` high sets protection-violation and does not start a sequence.
- R9: Status writes (`reg_sel` 1) clear access-error with bit 2 and protection-violation with bit 3. Bit 1 has no effect on command-complete.
- R10: While access-error or protection-violation is set, an array write is ignored. An array write made while buffer-empty is 0 sets access-error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_wr | input | 1 | Write strobe into the flash array window |
| arr_addr | input | ADDR_W | Array write address |
| arr_data | input | DATA_W | Array write data |
| prot_hit | input | 1 | Current array write targets a protected region |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 status, 2 divider |
| reg_wdata | input | 8 | Register write data |
| exec_done | input | 1 | Engine finished the running command |
| exec_start | output | 1 | One-cycle hand-off of a command to the engine |
| exec_op | output | 3 | Operation of the handed-off command |
| exec_addr | output | ADDR_W | Address of the handed-off command |
| exec_data | output | DATA_W | Data of the handed-off command |
| stat_bempty | output | 1 | Command buffer empty |
| stat_done | output | 1 | Command complete |
| stat_accerr | output | 1 | Access error |
| stat_pviol | output | 1 | Protection violation |
| div_loaded | output | 1 | Clock divider has been written since reset |

## Verification
The main path is driven once with each of the five operation codes, each time with a different address and data. This separates the opcode mapping from the capture of address and data. A back-to-back pair of launches, with the engine held busy, distinguishes a pipelined pending slot from a single buffer: buffer-empty and command-complete must stay low until the first done. Each kind of ordering fault is then applied in isolation, and the following writes show whether the sequence was really aborted or the write merely ignored. These faults include early command, repeated array write, bare launch, divider write mid-sequence, simultaneous strobes, a bad code, a launch before the divider is loaded, and a protection hit.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [2:0] {
        OP_BLANK = 3'd0,
        OP_PGVER = 3'd1,
        OP_PROG  = 3'd2,
        OP_PGERS = 3'd3,
        OP_MASS  = 3'd4
    } fcs_op_e;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DIV  = 2'd2,
        SEL_RSVD = 2'd3
    } fcs_sel_e;

    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_ADDR = 2'd1,
        STEP_CMD  = 2'd2
    } fcs_step_e;

    localparam logic [7:0] CODE_BLANK = 8'h11;
    localparam logic [7:0] CODE_PGVER = 8'h12;
    localparam logic [7:0] CODE_PROG  = 8'h21;
    localparam logic [7:0] CODE_PGERS = 8'h31;
    localparam logic [7:0] CODE_MASS  = 8'h32;

    localparam int BIT_LAUNCH = 0;
    localparam int BIT_DONE   = 1;
    localparam int BIT_ACCERR = 2;
    localparam int BIT_PVIOL  = 3;

    typedef struct packed {
        logic    ok;
        fcs_op_e op;
    } fcs_dec_t;

    function automatic fcs_dec_t decode_cmd(input logic [7:0] code);
        fcs_dec_t d;
        d.ok = 1'b1;
        d.op = OP_BLANK;
        case (code)
            CODE_BLANK: d.op = OP_BLANK;
            CODE_PGVER: d.op = OP_PGVER;
            CODE_PROG:  d.op = OP_PROG;
            CODE_PGERS: d.op = OP_PGERS;
            CODE_MASS:  d.op = OP_MASS;
            default:    d.ok = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fcs_step_ctrl.sv
module fcs_step_ctrl
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arr_wr,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              prot_hit,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              bempty,
    input  logic              accerr,
    input  logic              pviol,
    input  logic              div_loaded,
    output logic              launch_ok,
    output logic              set_accerr,
    output logic              set_pviol,
    output logic              clr_accerr,
    output logic              clr_pviol,
    output logic              div_wr,
    output fcs_op_e           stg_op,
    output logic [ADDR_W-1:0] stg_addr,
    output logic [DATA_W-1:0] stg_data
);

    fcs_step_e step_q, step_n;
    fcs_dec_t  dec;
    logic      cmd_wr, stat_wr, divsel_wr, launch_req, any_err;
    logic      cap_arr, cap_cmd;

    assign cmd_wr     = reg_wr && (reg_sel == SEL_CMD);
    assign stat_wr    = reg_wr && (reg_sel == SEL_STAT);
    assign divsel_wr  = reg_wr && (reg_sel == SEL_DIV);
    assign launch_req = stat_wr && reg_wdata[BIT_LAUNCH];
    assign any_err    = accerr || pviol;
    assign dec        = decode_cmd(reg_wdata);

    // Error flags are write-1-to-clear; bit BIT_DONE is deliberately unused.
    assign clr_accerr = stat_wr && reg_wdata[BIT_ACCERR];
    assign clr_pviol  = stat_wr && reg_wdata[BIT_PVIOL];

    always_comb begin
        step_n     = step_q;
        launch_ok  = 1'b0;
        set_accerr = 1'b0;
        set_pviol  = 1'b0;
        div_wr     = 1'b0;
        cap_arr    = 1'b0;
        cap_cmd    = 1'b0;
        if (arr_wr && reg_wr) begin
            set_accerr = 1'b1;
            step_n     = STEP_IDLE;
        end else if (arr_wr) begin
            if (step_q != STEP_IDLE) begin
                set_accerr = 1'b1;
                step_n     = STEP_IDLE;
            end else if (any_err) begin
                step_n = STEP_IDLE;          // blocked until errors cleared
            end else if (!bempty) begin
                set_accerr = 1'b1;
            end else if (prot_hit) begin
                set_pviol = 1'b1;
            end else begin
                cap_arr = 1'b1;
                step_n  = STEP_ADDR;
            end
        end else if (cmd_wr) begin
            if (step_q == STEP_ADDR && dec.ok) begin
                cap_cmd = 1'b1;
                step_n  = STEP_CMD;
            end else begin
                set_accerr = 1'b1;
                step_n     = STEP_IDLE;
            end
        end else if (divsel_wr) begin
            if (step_q != STEP_IDLE) begin
                set_accerr = 1'b1;
                step_n     = STEP_IDLE;
            end else begin
                div_wr = 1'b1;
            end
        end else if (launch_req) begin
            if (step_q == STEP_CMD && div_loaded) begin
                launch_ok = 1'b1;
            end else begin
                set_accerr = 1'b1;
            end
            step_n = STEP_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q   <= STEP_IDLE;
            stg_op   <= OP_BLANK;
            stg_addr <= '0;
            stg_data <= '0;
        end else begin
            step_q <= step_n;
            if (cap_arr) begin
                stg_addr <= arr_addr;
                stg_data <= arr_data;
            end
            if (cap_cmd) begin
                stg_op <= dec.op;
            end
        end
    end

endmodule

// File: rtl/fcs_launch_q.sv
module fcs_launch_q
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch_ok,
    input  fcs_op_e           stg_op,
    input  logic [ADDR_W-1:0] stg_addr,
    input  logic [DATA_W-1:0] stg_data,
    input  logic              exec_done,
    output logic              exec_start,
    output fcs_op_e           exec_op,
    output logic [ADDR_W-1:0] exec_addr,
    output logic [DATA_W-1:0] exec_data,
    output logic              pend_valid,
    output logic              done_evt
);

    logic busy_q;

    // Pending slot feeds the engine directly whenever the engine is idle.
    assign exec_start = pend_valid && !busy_q;
    assign done_evt   = busy_q && exec_done && !pend_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            busy_q     <= 1'b0;
            exec_op    <= OP_BLANK;
            exec_addr  <= '0;
            exec_data  <= '0;
        end else begin
            if (launch_ok) begin
                pend_valid <= 1'b1;
                exec_op    <= stg_op;
                exec_addr  <= stg_addr;
                exec_data  <= stg_data;
            end else if (exec_start) begin
                pend_valid <= 1'b0;
            end
            if (exec_start) begin
                busy_q <= 1'b1;
            end else if (exec_done) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fcs_status.sv
module fcs_status (
    input  logic clk,
    input  logic rst,
    input  logic launch_ok,
    input  logic done_evt,
    input  logic set_accerr,
    input  logic clr_accerr,
    input  logic set_pviol,
    input  logic clr_pviol,
    input  logic div_wr,
    output logic done,
    output logic accerr,
    output logic pviol,
    output logic div_loaded
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b1;
            accerr     <= 1'b0;
            pviol      <= 1'b0;
            div_loaded <= 1'b0;
        end else begin
            if (launch_ok) begin
                done <= 1'b0;
            end else if (done_evt) begin
                done <= 1'b1;
            end
            if (set_accerr) begin
                accerr <= 1'b1;
            end else if (clr_accerr) begin
                accerr <= 1'b0;
            end
            if (set_pviol) begin
                pviol <= 1'b1;
            end else if (clr_pviol) begin
                pviol <= 1'b0;
            end
            if (div_wr) begin
                div_loaded <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arr_wr,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              prot_hit,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              exec_done,
    output logic              exec_start,
    output logic [2:0]        exec_op,
    output logic [ADDR_W-1:0] exec_addr,
    output logic [DATA_W-1:0] exec_data,
    output logic              stat_bempty,
    output logic              stat_done,
    output logic              stat_accerr,
    output logic              stat_pviol,
    output logic              div_loaded
);

    logic              launch_ok, set_accerr, set_pviol, clr_accerr, clr_pviol;
    logic              div_wr, pend_valid, done_evt;
    fcs_op_e           stg_op, q_op;
    logic [ADDR_W-1:0] stg_addr;
    logic [DATA_W-1:0] stg_data;

    fcs_step_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_step (
        .clk        (clk),
        .rst        (rst),
        .arr_wr     (arr_wr),
        .arr_addr   (arr_addr),
        .arr_data   (arr_data),
        .prot_hit   (prot_hit),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .bempty     (stat_bempty),
        .accerr     (stat_accerr),
        .pviol      (stat_pviol),
        .div_loaded (div_loaded),
        .launch_ok  (launch_ok),
        .set_accerr (set_accerr),
        .set_pviol  (set_pviol),
        .clr_accerr (clr_accerr),
        .clr_pviol  (clr_pviol),
        .div_wr     (div_wr),
        .stg_op     (stg_op),
        .stg_addr   (stg_addr),
        .stg_data   (stg_data)
    );

    fcs_launch_q #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lq (
        .clk        (clk),
        .rst        (rst),
        .launch_ok  (launch_ok),
        .stg_op     (stg_op),
        .stg_addr   (stg_addr),
        .stg_data   (stg_data),
        .exec_done  (exec_done),
        .exec_start (exec_start),
        .exec_op    (q_op),
        .exec_addr  (exec_addr),
        .exec_data  (exec_data),
        .pend_valid (pend_valid),
        .done_evt   (done_evt)
    );

    fcs_status u_stat (
        .clk        (clk),
        .rst        (rst),
        .launch_ok  (launch_ok),
        .done_evt   (done_evt),
        .set_accerr (set_accerr),
        .clr_accerr (clr_accerr),
        .set_pviol  (set_pviol),
        .clr_pviol  (clr_pviol),
        .div_wr     (div_wr),
        .done       (stat_done),
        .accerr     (stat_accerr),
        .pviol      (stat_pviol),
        .div_loaded (div_loaded)
    );

    assign exec_op     = q_op;
    assign stat_bempty = !pend_valid;

endmodule

// File: rtl/fcs_chk.sv
module fcs_chk
    import fcs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       arr_wr,
    input logic       prot_hit,
    input logic       reg_wr,
    input logic [1:0] reg_sel,
    input logic [7:0] reg_wdata,
    input logic       exec_start,
    input logic       exec_done,
    input logic       stat_bempty,
    input logic       stat_done,
    input logic       stat_accerr,
    input logic       stat_pviol,
    input logic       div_loaded,
    input logic       launch_ok
);

    assert_handoff_frees_R2: assert property (@(posedge clk) disable iff (rst)
        exec_start |=> stat_bempty);

    assert_launch_clears_R3: assert property (@(posedge clk) disable iff (rst)
        launch_ok |=> (!stat_done && !stat_bempty));

    assert_done_needs_engine_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_done) |-> $past(exec_done));

    assert_no_start_undiv_R7: assert property (@(posedge clk) disable iff (rst)
        !div_loaded |-> !exec_start);

    assert_pviol_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_pviol) |-> $past(arr_wr && prot_hit));

    assert_accerr_w1c_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_accerr) |-> $past(reg_wr && reg_sel == SEL_STAT && reg_wdata[BIT_ACCERR]));

endmodule

bind flash_cmd_seq fcs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .arr_wr      (arr_wr),
    .prot_hit    (prot_hit),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .exec_start  (exec_start),
    .exec_done   (exec_done),
    .stat_bempty (stat_bempty),
    .stat_done   (stat_done),
    .stat_accerr (stat_accerr),
    .stat_pviol  (stat_pviol),
    .div_loaded  (div_loaded),
    .launch_ok   (launch_ok)
);

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int EW = 3 + AW + DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arr_wr = 1'b0, prot_hit = 1'b0, reg_wr = 1'b0, exec_done = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic [DW-1:0] arr_data = '0;
    logic [1:0]    reg_sel = 2'd0;
    logic [7:0]    reg_wdata = 8'h00;
    logic          exec_start, stat_bempty, stat_done, stat_accerr, stat_pviol, div_loaded;
    logic [2:0]    exec_op;
    logic [AW-1:0] exec_addr;
    logic [DW-1:0] exec_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [EW-1:0] sb[$];

    always #2 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_data(arr_data),
        .prot_hit(prot_hit), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .exec_done(exec_done), .exec_start(exec_start), .exec_op(exec_op),
        .exec_addr(exec_addr), .exec_data(exec_data), .stat_bempty(stat_bempty),
        .stat_done(stat_done), .stat_accerr(stat_accerr), .stat_pviol(stat_pviol),
        .div_loaded(div_loaded)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: every hand-off must match the next expected item.
    always @(negedge clk) begin
        if (!rst && exec_start) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R2: actual unexpected start op %0d, expected none", exec_op);
            end else begin
                logic [EW-1:0] e;
                e = sb.pop_front();
                if ({exec_op, exec_addr, exec_data} !== e) begin
                    n_bad++;
                    $display("FAIL R2: actual %0h expected %0h", {exec_op, exec_addr, exec_data}, e);
                end
            end
        end
    end

    task automatic wr_arr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic p);
        @(negedge clk); arr_wr = 1'b1; arr_addr = a; arr_data = d; prot_hit = p;
        @(negedge clk); arr_wr = 1'b0; prot_hit = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic wr_both();
        @(negedge clk); arr_wr = 1'b1; reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h21;
        @(negedge clk); arr_wr = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); exec_done = 1'b1;
        @(negedge clk); exec_done = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_err();
        wr_reg(2'd1, 8'h0C);
    endtask

    task automatic launch(input logic [7:0] code, input logic [2:0] op,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_arr(a, d, 1'b0);
        wr_reg(2'd0, code);
        sb.push_back({op, a, d});
        wr_reg(2'd1, 8'h01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] codes [5];
        codes = '{8'h11, 8'h12, 8'h21, 8'h31, 8'h32};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 bempty", 64'(stat_bempty), 1);
        check("R1 done", 64'(stat_done), 1);
        check("R1 accerr", 64'(stat_accerr), 0);
        check("R1 pviol", 64'(stat_pviol), 0);
        check("R1 divld", 64'(div_loaded), 0);
        check("R1 start", 64'(exec_start), 0);

        // R7 launch before divider loaded
        wr_arr(16'h0010, 32'h1, 1'b0);
        wr_reg(2'd0, 8'h21);
        wr_reg(2'd1, 8'h01);
        check("R7 accerr undiv", 64'(stat_accerr), 1);
        check("R7 bempty undiv", 64'(stat_bempty), 1);
        clr_err();
        check("R9 accerr cleared", 64'(stat_accerr), 0);
        wr_reg(2'd2, 8'h14);
        check("R7 divld", 64'(div_loaded), 1);

        // R2/R3/R4 each operation
        for (int i = 0; i < 5; i++) begin
            launch(codes[i], 3'(i), 16'(16'h0100 + i * 16'h0111), 32'hA5A50000 ^ 32'(i * 7));
            check("R3 done low at launch", 64'(stat_done), 0);
            check("R3 bempty low at launch", 64'(stat_bempty), 0);
            idle(1);
            check("R3 bempty back", 64'(stat_bempty), 1);
            check("R4 done held while busy", 64'(stat_done), 0);
            pulse_done();
            check("R4 done after engine", 64'(stat_done), 1);
            check("R2 accerr clean", 64'(stat_accerr), 0);
        end

        // R4 pipelined pair
        launch(8'h31, 3'd3, 16'hBEEF, 32'h11112222);
        idle(1);
        launch(8'h21, 3'd2, 16'h0042, 32'hCAFEF00D);
        check("R4 pending bempty", 64'(stat_bempty), 0);
        idle(2);
        check("R4 pending held", 64'(stat_bempty), 0);
        pulse_done();
        check("R4 no done with pending", 64'(stat_done), 0);
        idle(1);
        check("R4 second handed off", 64'(stat_bempty), 1);
        pulse_done();
        check("R4 done final", 64'(stat_done), 1);

        // R5 ordering faults
        wr_reg(2'd0, 8'h21);
        check("R5 cmd first", 64'(stat_accerr), 1);
        clr_err();
        wr_arr(16'h1, 32'h1, 1'b0);
        wr_arr(16'h2, 32'h2, 1'b0);
        check("R5 double array", 64'(stat_accerr), 1);
        clr_err();
        wr_arr(16'h3, 32'h3, 1'b0);
        wr_reg(2'd1, 8'h01);
        check("R5 bare launch", 64'(stat_accerr), 1);
        clr_err();
        wr_arr(16'h4, 32'h4, 1'b0);
        wr_reg(2'd2, 8'h14);
        check("R5 div mid-seq", 64'(stat_accerr), 1);
        clr_err();
        wr_both();
        check("R5 simultaneous", 64'(stat_accerr), 1);
        clr_err();

        // R6 bad code
        wr_arr(16'h5, 32'h5, 1'b0);
        wr_reg(2'd0, 8'h99);
        check("R6 bad code", 64'(stat_accerr), 1);
        check("R6 nothing buffered", 64'(stat_bempty), 1);
        clr_err();

        // R8 protection hit aborts
        wr_arr(16'h6, 32'h6, 1'b1);
        check("R8 pviol", 64'(stat_pviol), 1);
        check("R8 no accerr", 64'(stat_accerr), 0);
        wr_reg(2'd0, 8'h21);
        check("R8 sequence aborted", 64'(stat_accerr), 1);
        clr_err();
        check("R9 pviol cleared", 64'(stat_pviol), 0);
        check("R9 accerr cleared both", 64'(stat_accerr), 0);

        // R9 done bit not clearable
        wr_reg(2'd1, 8'h02);
        check("R9 done unaffected", 64'(stat_done), 1);

        // R10 array write ignored under error
        wr_reg(2'd0, 8'h21);
        wr_arr(16'h7, 32'h7, 1'b0);
        clr_err();
        wr_reg(2'd0, 8'h21);
        check("R10 array ignored", 64'(stat_accerr), 1);
        clr_err();

        // R10 array write while buffer full
        launch(8'h40 - 8'h0F, 3'd3, 16'h0A0A, 32'h0B0B0B0B);
        idle(1);
        launch(8'h32, 3'd4, 16'h0C0C, 32'h0D0D0D0D);
        wr_arr(16'h8, 32'h8, 1'b0);
        check("R10 full buffer", 64'(stat_accerr), 1);
        check("R10 pending kept", 64'(stat_bempty), 0);
        clr_err();
        pulse_done();
        idle(1);
        pulse_done();
        check("R4 done after drain", 64'(stat_done), 1);
        check("R2 all handed off", 64'(sb.size()), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule